// File: doc/BRIEF.md
# Key-Protected Independent Watchdog

This block is a watchdog timer whose countdown runs entirely on its own slow clock, separate from the system clock that drives its register port. Software talks to it through a small register port: a key register takes one of three magic values (unlock configuration, restart the countdown, start the watchdog), a 3-bit prescaler register and a 12-bit reload register set the timeout, and a status register shows which configuration values are still being carried into the slow domain.

Software unlocks the configuration registers, programs the prescaler and reload value, and then writes the start key. From then on it must write the restart key often enough, or the block raises its reset output for one slow-clock cycle and begins a new countdown. Once started, only a hardware reset stops the watchdog. Key writes cross into the slow domain as toggle events, so each bus write produces exactly one action there. Configuration values cross with a request/acknowledge handshake, and the matching status flag stays high until the acknowledge has returned.

Top module: `wdg_top`

## Requirements
- R1: After reset, the prescaler reads 0, the reload register reads 4095, the status register reads 0, and `wd_reset_o` is low.
- R2: Writes to the prescaler (address 1) or reload (address 2) registers are ignored unless the unlock key 16'h6B3C was written to the key register (address 0) beforehand.
- R3: Writing the start key 16'hC7D2, or any value other than the three keys, to the key register re-locks the configuration registers. The restart key 16'hA1E5 leaves the lock state unchanged.
- R4: The status register (address 3) has a prescaler-pending flag in bit 0 and a reload-pending flag in bit 1. A flag is set by an accepted write and clears once the value has reached the slow domain. A write to a register while its own flag is set is ignored.
- R5: The prescaler divides the slow clock by 4 shifted left by the prescaler code. With reload value R and divide D, consecutive expiries are exactly (R+1)*D slow-clock cycles apart.
- R6: On expiry, `wd_reset_o` is high for exactly one slow-clock cycle, the counter reloads, and expiries then repeat periodically.
- R7: After start, every restart-key write reloads the countdown and resets the prescaler, so writing the restart key more often than once per timeout period prevents any expiry.
- R8: Before the start key has been written, no expiry occurs, and the restart key has no effect.
- R9: The reload register keeps only bits 11:0 of the write data, and the prescaler register keeps bits 2:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock for the register port |
| wd_clk | input | 1 | Slow watchdog clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| bus_wr | input | 1 | Write strobe, one sys_clk cycle per write |
| bus_addr | input | 2 | Register address: 0 key, 1 prescaler, 2 reload, 3 status |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr (the key register reads 0) |
| wd_reset_o | output | 1 | Watchdog reset pulse in the wd_clk domain |

## Verification
The hardest case to reach is a second write to a configuration register while the first is still crossing domains. Only a few slow-clock cycles are available to land that write, and whether it was dropped is visible only in the value read back afterwards. The bench makes the second write within two system cycles of the first, reads the pending flag straight away, then polls status until it clears and checks that the first value survived. Timeout periods are measured between two consecutive expiries, counted on slow-clock edges. This removes the uncertain synchronizer latency of the key event, so the cycle count can be checked exactly.

// File: rtl/wdg_pkg.sv
`timescale 1ns/1ps
package wdg_pkg;

  localparam logic [1:0] ADDR_KEY    = 2'd0;
  localparam logic [1:0] ADDR_PRESC  = 2'd1;
  localparam logic [1:0] ADDR_RELOAD = 2'd2;
  localparam logic [1:0] ADDR_STAT   = 2'd3;

  localparam logic [15:0] KEY_UNLOCK  = 16'h6B3C;
  localparam logic [15:0] KEY_RESTART = 16'hA1E5;
  localparam logic [15:0] KEY_START   = 16'hC7D2;

  typedef enum logic [1:0] {
    KK_OTHER   = 2'd0,
    KK_UNLOCK  = 2'd1,
    KK_RESTART = 2'd2,
    KK_START   = 2'd3
  } key_kind_e;

  function automatic key_kind_e key_kind(input logic [15:0] d);
    case (d)
      KEY_UNLOCK:  return KK_UNLOCK;
      KEY_RESTART: return KK_RESTART;
      KEY_START:   return KK_START;
      default:     return KK_OTHER;
    endcase
  endfunction

  // Slow-clock cycles per countdown step for a prescaler code.
  function automatic int unsigned div_of(input int unsigned code);
    return 32'd4 << code;
  endfunction

endpackage

// File: rtl/wdg_evt_xfer.sv
`timescale 1ns/1ps
module wdg_evt_xfer #(
  parameter int STAGES = 2
) (
  input  logic src_clk,
  input  logic rst_n,
  input  logic src_pulse,
  input  logic dst_clk,
  output logic dst_pulse
);
  logic              tgl_q;
  logic [STAGES-1:0] sync_q;
  logic              seen_q;

  always_ff @(posedge src_clk or negedge rst_n) begin
    if (!rst_n) tgl_q <= 1'b0;
    else        tgl_q <= tgl_q ^ src_pulse;
  end

  always_ff @(posedge dst_clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      seen_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], tgl_q};
      seen_q <= sync_q[STAGES-1];
    end
  end

  assign dst_pulse = sync_q[STAGES-1] ^ seen_q;
endmodule

// File: rtl/wdg_cfg_xfer.sv
`timescale 1ns/1ps
module wdg_cfg_xfer #(
  parameter int          W       = 12,
  parameter logic [W-1:0] RST_VAL = '0,
  parameter int          STAGES  = 2
) (
  input  logic         src_clk,
  input  logic         rst_n,
  input  logic         src_load,
  input  logic [W-1:0] src_data,
  output logic [W-1:0] src_q,
  output logic         src_busy,
  input  logic         dst_clk,
  output logic [W-1:0] dst_q
);
  logic              req_q;
  logic [STAGES-1:0] ack_sync_q;
  logic [STAGES-1:0] req_sync_q;
  logic              done_q;

  always_ff @(posedge src_clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q      <= RST_VAL;
      req_q      <= 1'b0;
      ack_sync_q <= '0;
    end else begin
      ack_sync_q <= {ack_sync_q[STAGES-2:0], done_q};
      if (src_load) begin
        src_q <= src_data;
        req_q <= ~req_q;
      end
    end
  end

  assign src_busy = req_q ^ ack_sync_q[STAGES-1];

  // src_q is held steady while busy, so it is safe to sample here.
  always_ff @(posedge dst_clk or negedge rst_n) begin
    if (!rst_n) begin
      req_sync_q <= '0;
      done_q     <= 1'b0;
      dst_q      <= RST_VAL;
    end else begin
      req_sync_q <= {req_sync_q[STAGES-2:0], req_q};
      if (req_sync_q[STAGES-1] != done_q) begin
        dst_q  <= src_q;
        done_q <= req_sync_q[STAGES-1];
      end
    end
  end
endmodule

// File: rtl/wdg_core.sv
`timescale 1ns/1ps
module wdg_core
  import wdg_pkg::*;
#(
  parameter int RLW = 12,
  parameter int PW  = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_evt,
  input  logic           restart_evt,
  input  logic [PW-1:0]  presc_code,
  input  logic [RLW-1:0] reload_val,
  output logic           running,
  output logic           step,
  output logic           expire
);
  localparam int PCW = 2 + (1 << PW) - 1;

  logic [PCW-1:0] pcnt_q;
  logic [PCW-1:0] div_m1;
  logic [RLW-1:0] cnt_q;

  assign div_m1 = PCW'(div_of(32'(presc_code)) - 1);
  assign step   = running && (pcnt_q >= div_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      pcnt_q  <= '0;
      cnt_q   <= '1;
      expire  <= 1'b0;
    end else begin
      expire <= 1'b0;
      if (start_evt || (restart_evt && running)) begin
        running <= 1'b1;
        pcnt_q  <= '0;
        cnt_q   <= reload_val;
      end else if (running) begin
        if (step) begin
          pcnt_q <= '0;
          if (cnt_q == '0) begin
            expire <= 1'b1;
            cnt_q  <= reload_val;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end else begin
          pcnt_q <= pcnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/wdg_top.sv
`timescale 1ns/1ps
module wdg_top
  import wdg_pkg::*;
#(
  parameter int DW     = 16,
  parameter int RLW    = 12,
  parameter int PW     = 3,
  parameter int STAGES = 2
) (
  input  logic          sys_clk,
  input  logic          wd_clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [1:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          wd_reset_o
);
  localparam logic [RLW-1:0] RELOAD_RST = '1;
  localparam logic [PW-1:0]  PRESC_RST  = '0;

  key_kind_e      kind;
  logic           key_wr;
  logic           unlocked;
  logic           start_pulse, restart_pulse;
  logic           presc_load, reload_load;
  logic [PW-1:0]  presc_q, presc_wd;
  logic [RLW-1:0] reload_q, reload_wd;
  logic           presc_busy, reload_busy;
  logic           start_evt, restart_evt;
  logic           running, step;

  assign kind          = key_kind(bus_wdata[15:0]);
  assign key_wr        = bus_wr && (bus_addr == ADDR_KEY);
  assign start_pulse   = key_wr && (kind == KK_START);
  assign restart_pulse = key_wr && (kind == KK_RESTART);
  assign presc_load    = bus_wr && (bus_addr == ADDR_PRESC)  && unlocked && !presc_busy;
  assign reload_load   = bus_wr && (bus_addr == ADDR_RELOAD) && unlocked && !reload_busy;

  always_ff @(posedge sys_clk or negedge rst_n) begin
    if (!rst_n) unlocked <= 1'b0;
    else if (key_wr) begin
      if (kind == KK_UNLOCK)       unlocked <= 1'b1;
      else if (kind != KK_RESTART) unlocked <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADDR_PRESC:  bus_rdata = DW'(presc_q);
      ADDR_RELOAD: bus_rdata = DW'(reload_q);
      ADDR_STAT:   bus_rdata = DW'({reload_busy, presc_busy});
      default:     bus_rdata = '0;
    endcase
  end

  wdg_cfg_xfer #(.W(PW), .RST_VAL(PRESC_RST), .STAGES(STAGES)) u_presc (
    .src_clk(sys_clk), .rst_n(rst_n), .src_load(presc_load),
    .src_data(bus_wdata[PW-1:0]), .src_q(presc_q), .src_busy(presc_busy),
    .dst_clk(wd_clk), .dst_q(presc_wd)
  );

  wdg_cfg_xfer #(.W(RLW), .RST_VAL(RELOAD_RST), .STAGES(STAGES)) u_reload (
    .src_clk(sys_clk), .rst_n(rst_n), .src_load(reload_load),
    .src_data(bus_wdata[RLW-1:0]), .src_q(reload_q), .src_busy(reload_busy),
    .dst_clk(wd_clk), .dst_q(reload_wd)
  );

  wdg_evt_xfer #(.STAGES(STAGES)) u_start (
    .src_clk(sys_clk), .rst_n(rst_n), .src_pulse(start_pulse),
    .dst_clk(wd_clk), .dst_pulse(start_evt)
  );

  wdg_evt_xfer #(.STAGES(STAGES)) u_restart (
    .src_clk(sys_clk), .rst_n(rst_n), .src_pulse(restart_pulse),
    .dst_clk(wd_clk), .dst_pulse(restart_evt)
  );

  wdg_core #(.RLW(RLW), .PW(PW)) u_core (
    .clk(wd_clk), .rst_n(rst_n), .start_evt(start_evt),
    .restart_evt(restart_evt), .presc_code(presc_wd),
    .reload_val(reload_wd), .running(running), .step(step),
    .expire(wd_reset_o)
  );
endmodule

// File: rtl/wdg_chk.sv
`timescale 1ns/1ps
module wdg_chk
  import wdg_pkg::*;
#(
  parameter int DW  = 16,
  parameter int RLW = 12,
  parameter int PW  = 3
) (
  input logic           sys_clk,
  input logic           wd_clk,
  input logic           rst_n,
  input logic           bus_wr,
  input logic [1:0]     bus_addr,
  input logic [DW-1:0]  bus_wdata,
  input logic           unlocked,
  input logic [PW-1:0]  presc_q,
  input logic [RLW-1:0] reload_q,
  input logic           presc_busy,
  input logic           reload_busy,
  input logic           running,
  input logic           start_evt,
  input logic           restart_evt,
  input logic           wd_reset_o
);
  // R2
  locked_presc_chk: assert property (@(posedge sys_clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_PRESC && !unlocked) |=> $stable(presc_q));

  // R2
  locked_reload_chk: assert property (@(posedge sys_clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_RELOAD && !unlocked) |=> $stable(reload_q));

  // R3
  relock_chk: assert property (@(posedge sys_clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_KEY && bus_wdata[15:0] != KEY_UNLOCK &&
     bus_wdata[15:0] != KEY_RESTART) |=> !unlocked);

  // R4
  busy_presc_chk: assert property (@(posedge sys_clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_PRESC && presc_busy) |=> $stable(presc_q));

  // R4
  busy_reload_chk: assert property (@(posedge sys_clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_RELOAD && reload_busy) |=> $stable(reload_q));

  // R4
  busy_rise_chk: assert property (@(posedge sys_clk) disable iff (!rst_n)
    $rose(reload_busy) |-> $past(bus_wr && bus_addr == ADDR_RELOAD));

  // R6
  pulse_width_chk: assert property (@(posedge wd_clk) disable iff (!rst_n)
    wd_reset_o |=> !wd_reset_o);

  // R8
  idle_quiet_chk: assert property (@(posedge wd_clk) disable iff (!rst_n)
    !running |-> !wd_reset_o);

  // R7: each key write gives a one-cycle event in the slow domain
  single_evt_chk: assert property (@(posedge wd_clk) disable iff (!rst_n)
    (start_evt || restart_evt) |=> !(start_evt || restart_evt));
endmodule

bind wdg_top wdg_chk #(.DW(DW), .RLW(RLW), .PW(PW)) u_chk (
  .sys_clk(sys_clk), .wd_clk(wd_clk), .rst_n(rst_n), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .unlocked(unlocked),
  .presc_q(presc_q), .reload_q(reload_q), .presc_busy(presc_busy),
  .reload_busy(reload_busy), .running(running), .start_evt(start_evt),
  .restart_evt(restart_evt), .wd_reset_o(wd_reset_o)
);

// File: tb/tb_wdg_top.sv
`timescale 1ns/1ps
module tb_wdg_top;
  logic        sys_clk = 1'b0;
  logic        wd_clk  = 1'b0;
  logic        rst_n   = 1'b0;
  logic        bus_wr  = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [15:0] bus_wdata = 16'h0;
  logic [15:0] bus_rdata;
  logic        wd_reset_o;

  int checks = 0;
  int fails  = 0;
  int pulses = 0;

  localparam logic [15:0] K_UNL = 16'h6B3C;
  localparam logic [15:0] K_RST = 16'hA1E5;
  localparam logic [15:0] K_GO  = 16'hC7D2;

  always #4 sys_clk = ~sys_clk;
  initial begin
    #3;
    forever #20 wd_clk = ~wd_clk;
  end

  wdg_top dut (
    .sys_clk(sys_clk), .wd_clk(wd_clk), .rst_n(rst_n), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wd_reset_o(wd_reset_o)
  );

  always @(negedge wd_clk) if (wd_reset_o) pulses++;

  function automatic int period_of(input int reload, input int code);
    return (reload + 1) * (4 << code);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge sys_clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge sys_clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    @(negedge sys_clk);
    bus_addr = a;
    #1 v = int'(bus_rdata);
  endtask

  task automatic wait_idle(output int st);
    st = 1;
    for (int i = 0; i < 400 && st != 0; i++) rd(2'd3, st);
  endtask

  task automatic measure(output int per, output bit narrow);
    int guard = 0;
    per = 0; narrow = 1'b1;
    while (!wd_reset_o && guard < 20000) begin @(negedge wd_clk); guard++; end
    @(negedge wd_clk); per = 1;
    if (wd_reset_o) narrow = 1'b0;
    while (!wd_reset_o && per < 20000) begin @(negedge wd_clk); per++; end
  endtask

  task automatic t_reset();
    int v;
    rd(2'd1, v); chk(v == 0, "R1 prescaler", v, 0);
    rd(2'd2, v); chk(v == 4095, "R1 reload", v, 4095);
    rd(2'd3, v); chk(v == 0, "R1 status", v, 0);
    chk(wd_reset_o == 1'b0, "R1 reset out", int'(wd_reset_o), 0);
  endtask

  task automatic t_lock();
    int v, st;
    wr(2'd1, 16'd5);
    rd(2'd1, v); chk(v == 0, "R2 locked write ignored", v, 0);
    wr(2'd0, K_UNL); wr(2'd0, 16'h1234); wr(2'd1, 16'd5);
    rd(2'd1, v); chk(v == 0, "R3 non-key relocks", v, 0);
    wr(2'd0, K_UNL); wr(2'd0, K_RST); wr(2'd1, 16'd2);
    rd(2'd1, v); chk(v == 2, "R2 R3 unlocked write, restart keeps lock", v, 2);
    wait_idle(st);
  endtask

  task automatic t_pending();
    int v, st;
    wr(2'd2, 16'h7005);
    rd(2'd2, v); chk(v == 5, "R9 reload width", v, 5);
    wait_idle(st);
    wr(2'd1, 16'hFFF8);
    rd(2'd1, v); chk(v == 0, "R9 prescaler width", v, 0);
    wait_idle(st);
    wr(2'd2, 16'd3);
    wr(2'd2, 16'd9);
    rd(2'd3, v); chk(v == 2, "R4 reload pending bit1", v, 2);
    wait_idle(st); chk(st == 0, "R4 pending clears", st, 0);
    rd(2'd2, v); chk(v == 3, "R4 write while pending ignored", v, 3);
    wr(2'd1, 16'd0);
    rd(2'd3, v); chk(v == 1, "R4 prescaler pending bit0", v, 1);
    wait_idle(st); chk(st == 0, "R4 prescaler pending clears", st, 0);
  endtask

  task automatic t_prestart();
    int base;
    wr(2'd0, K_RST);
    base = pulses;
    repeat (200) @(negedge wd_clk);
    chk(pulses == base, "R8 no expiry before start", pulses - base, 0);
  endtask

  task automatic t_start();
    int per, v; bit narrow;
    wr(2'd0, K_GO);
    measure(per, narrow);
    measure(per, narrow);
    chk(per == period_of(3, 0), "R5 period div4", per, period_of(3, 0));
    chk(narrow, "R6 one-cycle pulse", int'(narrow), 1);
    measure(per, narrow);
    chk(per == period_of(3, 0), "R6 periodic", per, period_of(3, 0));
    wr(2'd1, 16'd1);
    rd(2'd1, v); chk(v == 0, "R3 start relocks", v, 0);
  endtask

  task automatic t_feed();
    int st, base, per; bit narrow;
    wr(2'd0, K_UNL); wr(2'd2, 16'd20); wait_idle(st); wr(2'd0, 16'h0000);
    wr(2'd0, K_RST);
    repeat (10) @(negedge wd_clk);
    base = pulses;
    for (int i = 0; i < 15; i++) begin
      repeat (150) @(negedge sys_clk);
      wr(2'd0, K_RST);
    end
    chk(pulses == base, "R7 restart key prevents expiry", pulses - base, 0);
    measure(per, narrow);
    chk(per == period_of(20, 0), "R5 R7 period after feeding stops", per, period_of(20, 0));
  endtask

  task automatic t_presc();
    int st, per; bit narrow;
    wr(2'd0, K_UNL); wr(2'd1, 16'd1); wait_idle(st); wr(2'd0, 16'h0001);
    measure(per, narrow);
    measure(per, narrow);
    chk(per == period_of(20, 1), "R5 period div8", per, period_of(20, 1));
  endtask

  initial begin
    #(8 * 190000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (10) @(negedge sys_clk);
    rst_n = 1'b1;
    repeat (4) @(negedge sys_clk);
    t_reset();
    t_lock();
    t_pending();
    t_prestart();
    t_start();
    t_feed();
    t_presc();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule